// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block reproduces the column address sequence that a synchronous DRAM walks through on its own during a read or write burst. A controller or a behavioural memory model gives it a starting column, a length code and an order bit, and pulses a start strobe. From the next clock on, the block presents one column per cycle, along with a valid flag and a flag that marks the final beat. The controller can then tell which column each data beat belongs to without repeating the device's wrap arithmetic itself.

Fixed-length bursts of 1, 2, 4 or 8 beats wrap inside the aligned block that holds the starting column. The order within that block is either sequential or interleaved. A full-page burst runs through all 256 columns in ascending order and keeps going until it is stopped. A stop strobe ends any burst; this covers both a burst-stop command and a precharge. A fresh start strobe replaces the running burst.

Top module: `sdram_colgen`

## Requirements
- R1: Once a cycle with `rst` high has passed, `valid_o` and `last_o` are low, and they stay low until a start strobe arrives.
- R2: In the cycle after `start_i` is sampled high, `valid_o` is high and `col_o` equals the sampled `start_col_i`.
- R3: The length code sets the number of beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 act as length 1. A fixed burst keeps `valid_o` high for exactly that many consecutive cycles and then drops it.
- R4: With `interleave_i` low and a fixed length BL, beat n shows `(S & ~(BL-1)) | ((S+n) & (BL-1))`, where S is the start column. Only the low log2(BL) bits change.
- R5: With `interleave_i` high and length 2, 4 or 8, beat n shows `S ^ n`.
- R6: A full-page burst shows `(S+n) mod 256` on beat n whatever `interleave_i` is. It stays valid past 256 beats until it is stopped, and `last_o` is never high during it.
- R7: `last_o` is high only on the final beat of a fixed-length burst, and this includes length 1.
- R8: `start_i` low with `stop_i` high during a burst makes `valid_o` low in the next cycle. It stays low until the next start.
- R9: `start_i` during an active burst restarts the sequence from the new column in the next cycle. It also wins over a `stop_i` in the same cycle.
- R10: `stop_i` while no burst is active has no effect, and `valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst using the inputs below |
| stop_i | input | 1 | Terminate the running burst (burst stop or precharge) |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench provokes three collisions in one cycle. In the first, a start strobe and a stop strobe arrive on the same edge in the middle of an 8-beat burst. The next cycle must show the new starting column with `valid_o` high, and the new burst must run its full length. In the second, a stop arrives while the block is idle and must leave `valid_o` low. In the third, the final beat of one burst is followed directly by a new start, which must produce back-to-back beats with no idle cycle between them. All expected columns come from the arithmetic formulas in the requirements, across every start column, every fixed length and both orders.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    parameter int COL_W = 8;

    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic             page;
        logic             ilv;
    } burst_cfg_t;

    function automatic logic [COL_W-1:0] wrap_mask(input logic [2:0] code);
        logic [COL_W-1:0] m;
        case (code)
            LEN_2:    m = COL_W'(1);
            LEN_4:    m = COL_W'(3);
            LEN_8:    m = COL_W'(7);
            LEN_PAGE: m = '1;
            default:  m = '0;
        endcase
        return m;
    endfunction

    function automatic burst_cfg_t make_cfg(input logic [COL_W-1:0] col,
                                            input logic [2:0] code,
                                            input logic ilv);
        burst_cfg_t c;
        c.base = col;
        c.mask = wrap_mask(code);
        c.page = (code == LEN_PAGE);
        c.ilv  = ilv && (code != LEN_PAGE);
        return c;
    endfunction

endpackage

// File: rtl/sdram_colgen_seq.sv
module sdram_colgen_seq
    import sdram_colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  burst_cfg_t       cfg_in,
    output burst_cfg_t       cfg_q,
    output logic [COL_W-1:0] cnt_q,
    output logic             active_q,
    output logic             final_beat
);

    assign final_beat = active_q && !cfg_q.page && (cnt_q == cfg_q.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            cfg_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            cfg_q    <= cfg_in;
        end else if (stop) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (final_beat) active_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    start_loads_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (active_q && cnt_q == '0));

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !active_q);

    // R7
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (final_beat && !start) |=> !active_q);

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !final_beat && !start && !stop)
        |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));

    // R6
    page_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && cfg_q.page && !stop) |=> active_q);

endmodule

// File: rtl/sdram_colgen_map.sv
module sdram_colgen_map
    import sdram_colgen_pkg::*;
(
    input  burst_cfg_t       cfg,
    input  logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] ilv_xor;

    assign seq_sum = cfg.base + cnt;
    assign ilv_xor = cfg.base ^ cnt;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!cfg.mask[b])
                col[b] = cfg.base[b];
            else if (cfg.ilv)
                col[b] = ilv_xor[b];
            else
                col[b] = seq_sum[b];
        end
    end

endmodule

// File: rtl/sdram_colgen.sv
module sdram_colgen
    import sdram_colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] cnt_q;
    logic             active_q;
    logic             final_beat;

    sdram_colgen_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .stop       (stop_i),
        .cfg_in     (make_cfg(start_col_i, len_code_i, interleave_i)),
        .cfg_q      (cfg_q),
        .cnt_q      (cnt_q),
        .active_q   (active_q),
        .final_beat (final_beat)
    );

    sdram_colgen_map u_map (
        .cfg (cfg_q),
        .cnt (cnt_q),
        .col (col_o)
    );

    assign valid_o = active_q;
    assign last_o  = final_beat;

    // R2
    first_col_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R4
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !start_i && !stop_i && !last_o)
        |=> (((col_o ^ $past(col_o)) & ~cfg_q.mask) == '0));

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    // R10
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !start_i) |=> !valid_o);

endmodule

// File: tb/sdram_colgen_tb_top.sv
module sdram_colgen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sdram_colgen dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .start_col_i  (start_col_i),
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .col_o        (col_o),
        .valid_o      (valid_o),
        .last_o       (last_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int code, input int ilv, input int n);
        int bl = len_of(code);
        int m  = bl - 1;
        if (code == 7) return (s + n) % 256;
        if (ilv != 0 && bl > 1) return s ^ n;
        return (s & ~m & 255) | ((s + n) & m);
    endfunction

    task automatic pulse_start(input int col, input int code, input int ilv, input bit with_stop);
        start_i      = 1'b1;
        stop_i       = with_stop;
        start_col_i  = col[7:0];
        len_code_i   = code[2:0];
        interleave_i = ilv[0];
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
    endtask

    task automatic run_burst(input int col, input int code, input int ilv);
        int bl = len_of(code);
        pulse_start(col, code, ilv, 1'b0);
        for (int n = 0; n < bl; n++) begin
            check("R3 valid", valid_o, 1);
            check(ilv != 0 ? "R5 col" : "R4 col", col_o, exp_col(col, code, ilv, n));
            check("R7 last", last_o, (n == bl - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R3 end", valid_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", valid_o, 0);
        check("R1 last", last_o, 0);

        // R10 stop while idle
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R10 idle stop", valid_o, 0);
        @(negedge clk);
        check("R10 idle stop", valid_o, 0);

        // R2 R4 R5 R7 sweep over all columns, fixed lengths, both orders
        for (int ilv = 0; ilv < 2; ilv++)
            for (int code = 0; code < 4; code++)
                for (int s = 0; s < 256; s++) begin
                    pulse_start(s, code, ilv, 1'b0);
                    check("R2 first", col_o, s);
                    for (int n = 0; n < len_of(code); n++) begin
                        check("R3 valid", valid_o, 1);
                        check(ilv != 0 ? "R5 col" : "R4 col", col_o, exp_col(s, code, ilv, n));
                        check("R7 last", last_o, (n == len_of(code) - 1) ? 1 : 0);
                        @(negedge clk);
                    end
                    check("R3 end", valid_o, 0);
                end

        // R3 reserved codes behave as length 1
        for (int code = 4; code < 7; code++) begin
            run_burst(8'h5a, code, 0);
            run_burst(8'hc3, code, 1);
        end

        // R6 full page wraps, ignores interleave, no last, runs until stopped
        pulse_start(250, 7, 1, 1'b0);
        for (int n = 0; n < 300; n++) begin
            check("R6 valid", valid_o, 1);
            check("R6 col", col_o, (250 + n) % 256);
            check("R6 last", last_o, 0);
            @(negedge clk);
        end
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R8 page stop", valid_o, 0);
        @(negedge clk);
        check("R8 stays low", valid_o, 0);

        // R8 stop in the middle of a fixed burst
        pulse_start(8'h10, 3, 0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R8 before stop", col_o, 8'h12);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R8 stop", valid_o, 0);
        check("R8 stop last", last_o, 0);
        repeat (8) @(negedge clk);
        check("R8 stays low", valid_o, 0);

        // R9 restart with simultaneous stop: start wins
        pulse_start(8'h20, 3, 1, 1'b0);
        @(negedge clk);
        pulse_start(8'h85, 2, 0, 1'b1);
        check("R9 restart valid", valid_o, 1);
        check("R9 restart col", col_o, 8'h85);
        @(negedge clk);
        check("R9 next col", col_o, 8'h86);
        @(negedge clk);
        check("R9 next col", col_o, 8'h87);
        @(negedge clk);
        check("R9 wrap col", col_o, 8'h84);
        check("R9 last", last_o, 1);
        @(negedge clk);
        check("R9 end", valid_o, 0);

        // R9 back-to-back: start on the final beat of a burst
        pulse_start(8'h41, 1, 0, 1'b0);
        check("R9 b2b first", col_o, 8'h41);
        @(negedge clk);
        check("R9 b2b last", last_o, 1);
        pulse_start(8'h33, 2, 1, 1'b0);
        check("R9 b2b valid", valid_o, 1);
        check("R9 b2b col", col_o, 8'h33);
        @(negedge clk);
        check("R5 b2b col", col_o, 8'h32);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule